// File: doc/BRIEF.md
# Latency-Balanced Pipelined Reset Distributor

This block carries a 16-bit bus of synchronous reset lines along one edge of a die to a row of tap points. It feeds each tap's local reset network with an 8-bit reset vector. The bus is split into two 8-bit groups. The low group travels in a register pipeline from the tap-0 end towards the far end. The high group travels in a second pipeline in the opposite direction. Every register stage sits between two neighbouring taps, so the raw depth seen at a tap depends on where it sits on the edge.

Each tap chooses one of the two groups and passes it through its own short delay line. The number of stages used in that line is set per tap. When each tap's extra stages fill the gap up to a common target depth, every tap sees each reset edge on the same clock cycle. This holds for assertion (line goes to 1) and for release (line goes to 0) alike.

The tap settings come out of the synchronous `init` input as a balanced forward-group setting. They can be reloaded through `cfg_load`, but only while the whole bus is held asserted. A small controller with three states gates the loads. CS_INIT is held while `init` is high. CS_HELD is entered when all 16 lines were asserted on the last clock. CS_LIVE is entered when any line was released. From any state, `init` leads to CS_INIT. From any other state, an all-ones bus leads to CS_HELD and anything else leads to CS_LIVE.

Top module: `rst_edge_dist`

## Requirements
- R1: Bits [7:0] of `rst_bus` form the forward group, which enters the pipeline next to tap 0. Bits [15:8] form the reverse group, which enters next to tap N-1. A tap with select 0 carries the forward group, and a tap with select 1 carries the reverse group.
- R2: With an extra count of 0, tap i's output follows its selected group with a latency of i+1 clocks (forward) or N-i clocks (reverse).
- R3: In the default setting after `init`, every tap reproduces the low byte of `rst_bus` exactly TARGET clocks later. Both rising and falling edges of every bit arrive on the same cycle at all taps.
- R4: Tap i's total latency is its raw depth plus its extra count. Tap i's extra count is `cfg_extra[i*EW +: EW]`, and its select is `cfg_sel[i]`. With select 1 and extra TARGET-(N-i), all taps carry the high byte with a latency of exactly TARGET.
- R5: While `init` is sampled high, every pipeline and delay register is set to 1. Every tap output therefore reads all ones on the following cycle, and stays at ones until real bus values have travelled through. Tap settings return to select 0 with extra TARGET-1-i.
- R6: A `cfg_load` pulse is taken at a clock edge only if, at the edge before it, all 16 bus lines were high and `init` was low (state CS_HELD). The new settings act from the next cycle.
- R7: A `cfg_load` pulse in CS_LIVE or CS_INIT is ignored: the tap outputs keep the latency and group of the settings in force before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock the reset lines are synchronous to |
| init | input | 1 | Synchronous initialisation of pipelines and settings, active high |
| rst_bus | input | 2*GRP_W (16) | Reset lines; high = asserted; [7:0] forward group, [15:8] reverse group |
| cfg_load | input | 1 | Load strobe for tap settings |
| cfg_sel | input | N_TAPS (6) | Per-tap group select, bit i for tap i |
| cfg_extra | input | N_TAPS*EW (18) | Per-tap extra stage count, field i at [i*EW +: EW] |
| tap_rst | output | N_TAPS*GRP_W (48) | Reset vector per tap, tap i at [i*GRP_W +: GRP_W] |

## Verification
A behavioural model in the bench keeps a history of captured bus values and the settings in force. Every clock it predicts each tap's byte, so single-bit pulses on every line check edge alignment across all taps in both directions. The bench also targets three settings. Zero extra stages exposes the raw per-tap depth, where a chain wired in the wrong direction or off by one stage would shift some taps by a cycle. The reverse-group balanced setting would leak low-byte activity if the select were swapped. A load attempted while lines are released must be refused, or taps would jump to unbalanced latencies. Finally, an `init` in the middle of traffic must force all outputs high at once and restore the forward setting. A design that missed this would leave stale zeros in the delay lines.

// File: rtl/rst_dist_pkg.sv
package rst_dist_pkg;

    typedef enum logic [1:0] {
        CS_INIT = 2'd0,
        CS_HELD = 2'd1,
        CS_LIVE = 2'd2
    } cfg_state_e;

    // extra stages that bring a forward-group tap up to the target depth
    function automatic int fwd_pad(input int idx, input int target);
        return target - 1 - idx;
    endfunction

endpackage

// File: rtl/rst_chain.sv
module rst_chain #(
    parameter int N   = 6,
    parameter int W   = 8,
    parameter bit REV = 1'b0
) (
    input  logic           clk,
    input  logic           init,
    input  logic [W-1:0]   din,
    output logic [N*W-1:0] taps
);
    logic [W-1:0] st [N];
    logic         init_q;

    generate
        for (genvar k = 0; k < N; k++) begin : g_stage
            if ((REV == 1'b0 && k == 0) || (REV == 1'b1 && k == N-1)) begin : g_head
                always_ff @(posedge clk) begin
                    if (init) st[k] <= '1;
                    else      st[k] <= din;
                end
            end else if (REV == 1'b0) begin : g_fwd
                always_ff @(posedge clk) begin
                    if (init) st[k] <= '1;
                    else      st[k] <= st[k-1];
                end
            end else begin : g_rev
                always_ff @(posedge clk) begin
                    if (init) st[k] <= '1;
                    else      st[k] <= st[k+1];
                end
            end
            assign taps[k*W +: W] = st[k];
        end
    endgenerate

    always_ff @(posedge clk) init_q <= init;

    // R5: every stage holds the asserted value right after init
    always @(posedge clk) begin
        if (init_q) begin
            a_r5_chain_filled: assert (&taps)
                else $error("chain not filled with asserted value after init");
        end
    end

endmodule

// File: rtl/rst_tap.sv
module rst_tap #(
    parameter int W    = 8,
    parameter int MAXE = 7,
    parameter int EW   = 3
) (
    input  logic          clk,
    input  logic          init,
    input  logic          sel,
    input  logic [EW-1:0] extra,
    input  logic [W-1:0]  fwd_in,
    input  logic [W-1:0]  rev_in,
    output logic [W-1:0]  out
);
    logic [W-1:0] pick;
    logic [W-1:0] line [MAXE];
    int           ext_eff;
    logic         init_q;

    assign pick    = sel ? rev_in : fwd_in;
    assign ext_eff = (int'(extra) > MAXE) ? MAXE : int'(extra);

    generate
        for (genvar j = 0; j < MAXE; j++) begin : g_line
            if (j == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (init) line[j] <= '1;
                    else      line[j] <= pick;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (init) line[j] <= '1;
                    else      line[j] <= line[j-1];
                end
            end
        end
    endgenerate

    always_comb begin
        out = pick;
        for (int j = 0; j < MAXE; j++) begin
            if (ext_eff == j + 1) out = line[j];
        end
    end

    always_ff @(posedge clk) init_q <= init;

    // R5: the tap output reads asserted right after init
    always @(posedge clk) begin
        if (init_q) begin
            a_r5_tap_asserted: assert (&out)
                else $error("tap output not asserted after init");
        end
    end

endmodule

// File: rtl/rst_cfg_ctrl.sv
module rst_cfg_ctrl
    import rst_dist_pkg::*;
#(
    parameter int N      = 6,
    parameter int TARGET = 8,
    parameter int EW     = 3,
    parameter int BUS_W  = 16
) (
    input  logic            clk,
    input  logic            init,
    input  logic [BUS_W-1:0] rst_bus,
    input  logic            cfg_load,
    input  logic [N-1:0]    cfg_sel,
    input  logic [N*EW-1:0] cfg_extra,
    output logic [N-1:0]    sel_q,
    output logic [N*EW-1:0] extra_q
);
    cfg_state_e state_q, state_d;
    logic       all_held;
    logic       cfg_we;

    assign all_held = &rst_bus;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_INIT: state_d = all_held ? CS_HELD : CS_LIVE;
            CS_HELD: state_d = all_held ? CS_HELD : CS_LIVE;
            CS_LIVE: state_d = all_held ? CS_HELD : CS_LIVE;
            default: state_d = CS_INIT;
        endcase
        if (init) state_d = CS_INIT;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_comb begin
        cfg_we = 1'b0;
        unique case (state_q)
            CS_HELD: cfg_we = cfg_load && !init;
            CS_INIT, CS_LIVE: cfg_we = 1'b0;
            default: cfg_we = 1'b0;
        endcase
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_cfg
            always_ff @(posedge clk) begin
                if (init) begin
                    sel_q[i]           <= 1'b0;
                    extra_q[i*EW +: EW] <= EW'(fwd_pad(i, TARGET));
                end else if (cfg_we) begin
                    sel_q[i]           <= cfg_sel[i];
                    extra_q[i*EW +: EW] <= cfg_extra[i*EW +: EW];
                end
            end
        end
    endgenerate

    // R6: a load is only taken after a cycle with every line asserted
    a_r6_load_needs_hold: assert property (@(posedge clk) disable iff (init)
        cfg_we |-> ($past(&rst_bus) && !$past(init)))
        else $error("settings load accepted without a held bus");

    // R7: settings stay frozen outside the held state
    a_r7_cfg_frozen_live: assert property (@(posedge clk) disable iff (init)
        (state_q != CS_HELD) |=> ($stable(sel_q) && $stable(extra_q)))
        else $error("settings changed outside the held state");

endmodule

// File: rtl/rst_edge_dist.sv
module rst_edge_dist #(
    parameter int N_TAPS = 6,
    parameter int GRP_W  = 8,
    parameter int TARGET = 8,
    parameter int EW     = (TARGET > 1) ? $clog2(TARGET) : 1
) (
    input  logic                    clk,
    input  logic                    init,
    input  logic [2*GRP_W-1:0]      rst_bus,
    input  logic                    cfg_load,
    input  logic [N_TAPS-1:0]       cfg_sel,
    input  logic [N_TAPS*EW-1:0]    cfg_extra,
    output logic [N_TAPS*GRP_W-1:0] tap_rst
);
    localparam int MAXE  = TARGET - 1;
    localparam int BUS_W = 2 * GRP_W;

    logic [N_TAPS*GRP_W-1:0] fwd_taps;
    logic [N_TAPS*GRP_W-1:0] rev_taps;
    logic [N_TAPS-1:0]       sel_q;
    logic [N_TAPS*EW-1:0]    extra_q;
    logic                    init_q;

    rst_chain #(.N(N_TAPS), .W(GRP_W), .REV(1'b0)) u_fwd (
        .clk  (clk),
        .init (init),
        .din  (rst_bus[GRP_W-1:0]),
        .taps (fwd_taps)
    );

    rst_chain #(.N(N_TAPS), .W(GRP_W), .REV(1'b1)) u_rev (
        .clk  (clk),
        .init (init),
        .din  (rst_bus[BUS_W-1:GRP_W]),
        .taps (rev_taps)
    );

    rst_cfg_ctrl #(.N(N_TAPS), .TARGET(TARGET), .EW(EW), .BUS_W(BUS_W)) u_ctrl (
        .clk       (clk),
        .init      (init),
        .rst_bus   (rst_bus),
        .cfg_load  (cfg_load),
        .cfg_sel   (cfg_sel),
        .cfg_extra (cfg_extra),
        .sel_q     (sel_q),
        .extra_q   (extra_q)
    );

    generate
        for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
            rst_tap #(.W(GRP_W), .MAXE(MAXE), .EW(EW)) u_tap (
                .clk    (clk),
                .init   (init),
                .sel    (sel_q[i]),
                .extra  (extra_q[i*EW +: EW]),
                .fwd_in (fwd_taps[i*GRP_W +: GRP_W]),
                .rev_in (rev_taps[i*GRP_W +: GRP_W]),
                .out    (tap_rst[i*GRP_W +: GRP_W])
            );
        end
    endgenerate

    always_ff @(posedge clk) init_q <= init;

    // R5: whole output vector asserted right after init
    always @(posedge clk) begin
        if (init_q) begin
            a_r5_outputs_asserted: assert (&tap_rst)
                else $error("tap outputs not all asserted after init");
        end
    end

endmodule

// File: tb/rst_edge_dist_tb_top.sv
module rst_edge_dist_tb_top;
    localparam int N  = 6;
    localparam int W  = 8;
    localparam int TG = 8;
    localparam int EW = 3;
    localparam int HD = 2 * TG;

    logic            clk = 1'b0;
    logic            init = 1'b0;
    logic [2*W-1:0]  rst_bus = '1;
    logic            cfg_load = 1'b0;
    logic [N-1:0]    cfg_sel = '0;
    logic [N*EW-1:0] cfg_extra = '0;
    logic [N*W-1:0]  tap_rst;

    always #2.5 clk = ~clk;

    rst_edge_dist #(.N_TAPS(N), .GRP_W(W), .TARGET(TG), .EW(EW)) dut_i (
        .clk(clk), .init(init), .rst_bus(rst_bus), .cfg_load(cfg_load),
        .cfg_sel(cfg_sel), .cfg_extra(cfg_extra), .tap_rst(tap_rst)
    );

    // reference model state
    logic [2*W-1:0] hist [$];
    int  m_sel [N];
    int  m_ext [N];
    bit  m_held = 0;
    bit  armed = 0;
    int  n_vec = 0;
    int  n_bad = 0;
    int  cyc = 0;
    string cur_req = "R5";

    task automatic model_edge();
        bit take;
        take = cfg_load && m_held && !init;
        if (init) begin
            for (int k = 0; k < HD; k++) hist[k] = '1;
            for (int i = 0; i < N; i++) begin
                m_sel[i] = 0;
                m_ext[i] = TG - 1 - i;
            end
            armed = 1;
        end else begin
            hist.push_front(rst_bus);
            void'(hist.pop_back());
            if (take) begin
                for (int i = 0; i < N; i++) begin
                    m_sel[i] = int'(cfg_sel[i]);
                    m_ext[i] = int'(cfg_extra[i*EW +: EW]);
                end
            end
        end
        m_held = !init && (&rst_bus);
    endtask

    task automatic compare();
        logic [W-1:0] exp_v;
        int lat;
        if (!armed) return;
        for (int i = 0; i < N; i++) begin
            lat = (m_sel[i] != 0 ? N - i : i + 1) + (m_ext[i] > TG-1 ? TG-1 : m_ext[i]);
            exp_v = (m_sel[i] != 0) ? hist[lat-1][2*W-1:W] : hist[lat-1][W-1:0];
            n_vec++;
            if (tap_rst[i*W +: W] !== exp_v) begin
                n_bad++;
                $display("FAIL %s cycle %0d tap %0d: got %h expected %h",
                         cur_req, cyc, i, tap_rst[i*W +: W], exp_v);
            end
        end
    endtask

    task automatic step(int n);
        for (int c = 0; c < n; c++) begin
            @(posedge clk);
            cyc++;
            model_edge();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic load(logic [N-1:0] s, logic [N*EW-1:0] e);
        cfg_sel = s; cfg_extra = e; cfg_load = 1'b1;
        step(1);
        cfg_load = 1'b0;
    endtask

    task automatic pulse_bits(int lo, int hi);
        for (int b = lo; b < hi; b++) begin
            rst_bus = '1; rst_bus[b] = 1'b0;
            step(1);
            rst_bus = '1;
            step(3);
        end
    endtask

    // watchdog
    initial begin
        #(5ns * 100000);
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [N*EW-1:0] ext_rev;
        for (int k = 0; k < HD; k++) hist.push_back('1);
        for (int i = 0; i < N; i++) begin m_sel[i] = 0; m_ext[i] = 0; end

        // R5: initialisation, outputs asserted
        @(negedge clk);
        init = 1'b1; rst_bus = '0;
        step(3);
        n_vec++;
        if (tap_rst !== '1) begin
            n_bad++;
            $display("FAIL R5 reset state: got %h expected all ones", tap_rst);
        end
        init = 1'b0; rst_bus = '1;
        step(TG + 2);

        // R3: balanced default, release and reassert together, then single-bit pulses
        cur_req = "R3";
        rst_bus = '0; step(TG + 4);
        rst_bus = '1; step(TG + 4);
        pulse_bits(0, W);
        rst_bus = 16'h5A3C; step(2);
        rst_bus = 16'hA5C3; step(TG + 2);

        // R7: load attempted while lines are released must be ignored
        cur_req = "R7";
        rst_bus = 16'h00F0; step(1);
        load('1, '0);
        rst_bus = 16'h0F00; step(2);
        rst_bus = 16'hFF0F; step(TG + 2);
        pulse_bits(0, 4);

        // R1 / R4: reverse group balanced
        cur_req = "R4";
        rst_bus = '1; step(TG + 4);
        for (int i = 0; i < N; i++) ext_rev[i*EW +: EW] = EW'(TG - (N - i));
        load('1, ext_rev);
        step(TG + 2);
        cur_req = "R1";
        pulse_bits(W, 2*W);
        rst_bus = 16'hFF00; step(4);
        rst_bus = 16'h00FF; step(TG + 4);

        // R2: zero extra, raw depth visible, both groups
        cur_req = "R6";
        rst_bus = '1; step(TG + 4);
        load('0, '0);
        cur_req = "R2";
        step(TG);
        pulse_bits(0, 3);
        rst_bus = 16'hFFF0; step(5);
        rst_bus = '1; step(TG + 2);
        cur_req = "R6";
        load('1, '0);
        cur_req = "R2";
        pulse_bits(W, W + 3);
        rst_bus = 16'h0FFF; step(5);
        rst_bus = '1; step(TG + 2);

        // R5: init in mid traffic forces ones and restores default
        cur_req = "R5";
        rst_bus = 16'h0000; step(TG + 4);
        init = 1'b1; step(1);
        n_vec++;
        if (tap_rst !== '1) begin
            n_bad++;
            $display("FAIL R5 mid-traffic init: got %h expected all ones", tap_rst);
        end
        init = 1'b0;
        cur_req = "R3";
        step(TG + 4);
        pulse_bits(0, 2);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule